// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block sits on the host side of an asynchronous byte-wide EEPROM and turns a stream of byte write requests into strobe-controlled write cycles on the memory pins. Each request arrives on a ready/valid channel with an address and a data byte. The sequencer drives the address bus, the data bus and its output enable, and the active-low chip-enable, output-enable and write-enable lines. Every pulse width, setup and hold limit is counted in clock cycles. Each limit is derived from a clock-frequency parameter and rounded up.

Successive requests that land in the same aligned page are loaded into one page write. This holds as long as each one starts within the byte-load window that follows the previous strobe. When the window runs out, or a request addresses a different page, the page is closed. The sequencer then holds ready low for the worst-case internal programming time, and only after that does it accept the next byte.

Top module: `eeprom_page_writer`

## Requirements
- R1: Each accepted request produces exactly one write-enable low pulse, in acceptance order, with `mem_addr_o` and `mem_dq_o` equal to that request's address and data while the pulse is low.
- R2: Write-enable stays low for at least ceil(T_WP_NS·CLK_MHZ/1000) cycles. Address and data do not change while it is low, and `mem_dq_oe_o` is 1 throughout.
- R3: `mem_oe_n_o` is 1 at all times. Chip-enable is low in every cycle in which write-enable is low. Each chip-enable low interval lasts at least ceil(T_CW_NS·CLK_MHZ/1000) cycles.
- R4: `mem_dq_oe_o` is 1 only in cycles in which chip-enable is low.
- R5: Within a page, consecutive write-enable falling edges are at least ceil(T_BLC_MIN_NS·CLK_MHZ/1000) and at most ceil(T_BLC_MAX_NS·CLK_MHZ/1000) cycles apart. A request that arrives earlier than the minimum is held off until the minimum is met.
- R6: If no request is accepted before the byte-load window ends, the page closes. `req_ready_o` is then 0 during the programming wait, and the next write-enable falling edge comes at least max(ceil(T_WC_NS·f), ceil(T_DW_NS·f)) cycles after the previous one.
- R7: A request whose address bits above the page offset (bits ADDR_W-1 down to log2(PAGE_BYTES)) differ from those of the open page is not accepted into it. The page closes, and that request's strobe comes at least the programming wait (as in R6) after the previous falling edge.
- R8: While reset is asserted, `req_ready_o` is 0, `mem_we_n_o` and `mem_ce_n_o` are 1, and `mem_dq_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid is also high |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_data_i | input | DATA_W | Byte to store |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_o | output | DATA_W | Memory data bus value |
| mem_dq_oe_o | output | 1 | Data bus drive enable (0 = tri-stated) |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low, held inactive |
| mem_we_n_o | output | 1 | Write enable, active low |

## Verification
Four patterns are used. Back-to-back bytes in one page are offered with no idle time; they show that the minimum byte-load spacing holds off a ready source. A byte offered after a medium idle gap separates "still inside the window" from "window expired". It is followed by a long idle gap, which must close the page and produce the full programming wait. Address sequences are chosen to step across a page boundary by one byte, to jump between distant pages, and to walk backwards inside a page. Together they show that page closure follows the page tag and not address order or adjacency.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_OPEN,
    ST_PROG
  } wr_state_e;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int ns2cyc(input longint ns, input longint mhz);
    return int'((ns * mhz + 64'd999) / 64'd1000);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eepw_cycle_timer.sv
module eepw_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_d;
  end

endmodule

// File: rtl/eepw_page_match.sv
module eepw_page_match #(
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);

  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= '0;
    else if (load) tag_q <= load_tag;
  end

  assign hit = (probe_tag == tag_q);

endmodule

// File: rtl/eepw_strobe_out.sv
module eepw_strobe_out
  import eepw_pkg::*;
#(
  parameter int AW     = 13,
  parameter int DW     = 8,
  parameter int WLOW_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_state_e     state_d,
  input  logic          load,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          ce_n_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic          dq_oe_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o
);

  localparam int LW = $clog2(WLOW_N + 2);

  logic ce_n_d, we_n_d, dq_oe_d;
  logic [LW-1:0] low_cnt_q;

  always_comb begin
    ce_n_d  = !(state_d == ST_SETUP || state_d == ST_STROBE || state_d == ST_HOLD);
    we_n_d  = (state_d != ST_STROBE);
    dq_oe_d = !ce_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_n_o  <= ce_n_d;
      we_n_o  <= we_n_d;
      dq_oe_o <= dq_oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (load) begin
      addr_o <= addr_i;
      dq_o   <= data_i;
    end
  end

  assign oe_n_o = 1'b1;

  // Length of the current write-enable low run, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt_q <= '0;
    else if (we_n_o)                    low_cnt_q <= '0;
    else if (low_cnt_q != {LW{1'b1}})   low_cnt_q <= low_cnt_q + LW'(1);
  end

  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> !ce_n_o);

  p_drive_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> !ce_n_o);

  p_we_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(dq_o) && $stable(addr_o) && dq_oe_o));

  p_we_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_o) |-> (low_cnt_q >= LW'(WLOW_N)));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int CLK_MHZ      = 50,
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 64,
  parameter int T_WP_NS      = 50,
  parameter int T_WPH_NS     = 50,
  parameter int T_DS_NS      = 50,
  parameter int T_CW_NS      = 50,
  parameter int T_BLC_MIN_NS = 150,
  parameter int T_BLC_MAX_NS = 100000,
  parameter int T_WC_NS      = 5000000,
  parameter int T_DW_NS      = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o
);

  // Cycle counts for each timing limit.
  localparam int WLOW_N = imax(imax(ns2cyc(T_WP_NS, CLK_MHZ), ns2cyc(T_DS_NS, CLK_MHZ)),
                               imax(ns2cyc(T_CW_NS, CLK_MHZ) - 2, 1));
  localparam int WPH_N      = ns2cyc(T_WPH_NS, CLK_MHZ);
  localparam int BMIN_N     = ns2cyc(T_BLC_MIN_NS, CLK_MHZ);
  localparam int BMAX_N     = ns2cyc(T_BLC_MAX_NS, CLK_MHZ);
  localparam int BUSY_N     = imax(ns2cyc(T_WC_NS, CLK_MHZ), ns2cyc(T_DW_NS, CLK_MHZ));
  // Strobe-to-strobe distance is WLOW_N + 2 + (cycles spent in ST_OPEN).
  localparam int OPEN_MIN_N = imax(1, imax(BMIN_N - WLOW_N - 2, WPH_N - 2));
  localparam int OPEN_MAX_N = imax(OPEN_MIN_N, BMAX_N - WLOW_N - 2);
  localparam int CNT_MAX    = imax(BUSY_N, imax(OPEN_MAX_N, WLOW_N));
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int TAG_W      = ADDR_W - OFF_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sn;
  wr_state_e        state_q, state_d;
  logic             accept, page_hit, window_ok;
  logic [CNT_W-1:0] cnt;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign window_ok = (cnt >= CNT_W'(OPEN_MIN_N - 1));

  always_comb begin
    state_d     = state_q;
    accept      = 1'b0;
    req_ready_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready_o = rst_sn;
        if (req_valid_i && rst_sn) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: if (cnt == CNT_W'(WLOW_N - 1)) state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_OPEN;
      ST_OPEN: begin
        req_ready_o = window_ok && page_hit;
        if (req_valid_i && window_ok && page_hit) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
        end else if (req_valid_i && window_ok && !page_hit) begin
          state_d = ST_PROG;
        end else if (cnt == CNT_W'(OPEN_MAX_N - 1)) begin
          state_d = ST_PROG;
        end
      end
      ST_PROG:   if (cnt == CNT_W'(BUSY_N - 1)) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  eepw_cycle_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (state_d != state_q),
    .cnt_o (cnt)
  );

  eepw_page_match #(.TAG_W(TAG_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (accept),
    .load_tag  (req_addr_i[ADDR_W-1:OFF_W]),
    .probe_tag (req_addr_i[ADDR_W-1:OFF_W]),
    .hit       (page_hit)
  );

  eepw_strobe_out #(.AW(ADDR_W), .DW(DATA_W), .WLOW_N(WLOW_N)) u_strobe (
    .clk     (clk),
    .rst_n   (rst_sn),
    .state_d (state_d),
    .load    (accept),
    .addr_i  (req_addr_i),
    .data_i  (req_data_i),
    .ce_n_o  (mem_ce_n_o),
    .we_n_o  (mem_we_n_o),
    .oe_n_o  (mem_oe_n_o),
    .dq_oe_o (mem_dq_oe_o),
    .addr_o  (mem_addr_o),
    .dq_o    (mem_dq_o)
  );

  // A byte joined to an open page carries the same page tag as the previous one.
  p_open_page_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(state_q == ST_OPEN) && state_q == ST_SETUP) |->
      (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));

  // No acceptance while the programming wait runs.
  p_busy_ready_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_PROG) |=> (state_q != ST_SETUP));

endmodule

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

  localparam int CLK_PERIOD = 20;          // 50 MHz
  // Expected cycle limits, from the requirements at 50 MHz.
  localparam int EXP_WP   = 3;             // ceil(50 ns)
  localparam int EXP_CW   = 3;
  localparam int EXP_BMIN = 8;             // ceil(150 ns)
  localparam int EXP_BMAX = 100;           // 2000 ns
  localparam int EXP_BUSY = 1000;          // max(20000 ns, 10000 ns)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic req_ready, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_writer #(
    .CLK_MHZ(50), .ADDR_W(13), .DATA_W(8), .PAGE_BYTES(64),
    .T_BLC_MAX_NS(2000), .T_WC_NS(20000), .T_DW_NS(10000)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .mem_addr_o(mem_addr), .mem_dq_o(mem_dq), .mem_dq_oe_o(mem_dq_oe),
    .mem_ce_n_o(mem_ce_n), .mem_oe_n_o(mem_oe_n), .mem_we_n_o(mem_we_n)
  );

  typedef struct {
    logic [12:0] a;
    logic [7:0]  d;
    bit          np;
    string       req;
  } item_t;

  item_t exp_q[$];
  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Driver: queue the expected strobe, then hand the request over.
  task automatic send(input logic [12:0] a, input logic [7:0] d, input bit np, input string req);
    item_t it;
    it.a = a; it.d = d; it.np = np; it.req = req;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  int cyc = 0;
  int last_fall = -1;
  int low_run = 0;
  int ce_run = 0;
  int oe_viol = 0, drv_viol = 0, wece_viol = 0, stab_viol = 0;
  logic we_q = 1'b1, ce_q = 1'b1;
  logic [12:0] fa;
  logic [7:0]  fd;
  item_t cur;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!mem_oe_n) oe_viol++;
      if (mem_dq_oe && mem_ce_n) drv_viol++;
      if (!mem_we_n && mem_ce_n) wece_viol++;
      if (!mem_we_n) begin
        if (we_q) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 strobe with no pending request", 1, 0);
          end else begin
            cur = exp_q.pop_front();
            chk(mem_addr == cur.a, "R1 address", mem_addr, cur.a);
            chk(mem_dq == cur.d, "R1 data", mem_dq, cur.d);
            chk(mem_dq_oe == 1'b1, "R2 bus driven at strobe", mem_dq_oe, 1);
            if (last_fall >= 0) begin
              if (cur.np) begin
                chk(cyc - last_fall >= EXP_BUSY, {cur.req, " programming wait"},
                    cyc - last_fall, EXP_BUSY);
              end else begin
                chk(cyc - last_fall >= EXP_BMIN, "R5 min byte gap", cyc - last_fall, EXP_BMIN);
                chk(cyc - last_fall <= EXP_BMAX, "R5 max byte gap", cyc - last_fall, EXP_BMAX);
              end
            end
          end
          last_fall = cyc;
          fa = mem_addr;
          fd = mem_dq;
          low_run = 1;
        end else begin
          low_run++;
          if (mem_addr !== fa || mem_dq !== fd || !mem_dq_oe) stab_viol++;
        end
      end else if (!we_q) begin
        chk(low_run >= EXP_WP, "R2 write pulse width", low_run, EXP_WP);
      end
      if (!mem_ce_n) ce_run++;
      else if (!ce_q) begin
        chk(ce_run >= EXP_CW, "R3 chip enable width", ce_run, EXP_CW);
        ce_run = 0;
      end
      we_q = mem_we_n;
      ce_q = mem_ce_n;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    summary();
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R8 ready in reset", req_ready, 0);
    chk(mem_we_n == 1'b1, "R8 we_n in reset", mem_we_n, 1);
    chk(mem_ce_n == 1'b1, "R8 ce_n in reset", mem_ce_n, 1);
    chk(mem_dq_oe == 1'b0, "R8 bus released in reset", mem_dq_oe, 0);
    rst_n = 1'b1;
    idle(4);

    // R5: back-to-back bytes in one page (0x100..0x13F)
    send(13'h0100, 8'hA1, 1'b1, "R5");
    send(13'h0101, 8'hB2, 1'b0, "R5");
    send(13'h0105, 8'hC3, 1'b0, "R5");
    send(13'h013F, 8'hD4, 1'b0, "R5");
    // R7: one byte past the page end
    send(13'h0140, 8'hE5, 1'b1, "R7");
    // R5: inside the window after an idle gap
    idle(50);
    send(13'h0141, 8'h16, 1'b0, "R5");
    // R6: window expires, page closes
    idle(200);
    chk(req_ready == 1'b0, "R6 ready low while programming", req_ready, 0);
    send(13'h0142, 8'h27, 1'b1, "R6");
    // R7: far page, then walking backwards inside it
    send(13'h1FFF, 8'h38, 1'b1, "R7");
    send(13'h1FC0, 8'h49, 1'b0, "R5");
    send(13'h1FE0, 8'h5A, 1'b0, "R5");
    send(13'h0000, 8'h6B, 1'b1, "R7");

    idle(40);
    chk(exp_q.size() == 0, "R1 all requests strobed", exp_q.size(), 0);
    chk(oe_viol == 0, "R3 output enable stayed high", oe_viol, 0);
    chk(wece_viol == 0, "R3 write strobe inside chip enable", wece_viol, 0);
    chk(drv_viol == 0, "R4 bus drive only with chip enable", drv_viol, 0);
    chk(stab_viol == 0, "R2 bus stable while strobe low", stab_viol, 0);
    summary();
    $finish;
  end

endmodule